// File: doc/BRIEF.md
# Data-Cache Store Pipeline with Load Issue Interlock

This block carries stores into a direct-mapped data cache over three pipeline stages and keeps loads from colliding with them. A store reads the tag array in its first stage, the same stage in which a load would read the cache. It compares for a hit in the second stage. On a hit it writes the selected bytes of the data array in the third stage. A store that misses leaves the data array untouched and raises a miss pulse toward the write path.

A load reads the tag array and the data array together in its first stage. The data array has a single port, and a store's write uses that port in the cycle two after the store issued. The block therefore raises `ld_block` in exactly that cycle. Other stores may still issue in that cycle, so stores can issue one per cycle. A load presented while `ld_block` is high is dropped. A line install port loads a tag and a full word, so that the array has contents to hit on.

Top module: `dcache_store_pipe`

## Requirements
- R1: After reset, `ld_block`, `dwr_en`, `st_miss` and `ld_rsp_vld` are low, and every line is invalid, so a load that follows reset misses.
- R2: A line install (`fill_vld`) marks the line at index `fill_addr[IDX_W-1:0]` valid, with tag `fill_addr[ADDR_W-1:IDX_W]` and word `fill_data`.
- R3: A store reads the tag in its issue cycle. It hits when the line is valid and its stored tag equals the store's upper address bits. `dwr_en` is high in the second cycle after a hitting store issues, and in no other cycle.
- R4: A hitting store changes only the bytes whose `st_be` bit is set, where bit i covers data bits 8i+7 down to 8i. All other bytes of the word keep their values.
- R5: A missing store never changes the data array. `st_miss` is high in the second cycle after it issues, with `st_miss_addr` equal to its address.
- R6: `ld_block` is high in the cycle exactly two after each store issue, and low in every other cycle.
- R7: A load presented while `ld_block` is high is dropped. No response follows in the next cycle, and the array is unchanged.
- R8: Stores may issue on consecutive cycles. Each store's write lands in issue order, so the last store to write a byte wins.
- R9: A load issued one cycle after a store returns the old word. A load issued three or more cycles after it returns the updated word.
- R10: `ld_rsp_vld` is high in the cycle after an accepted load. In that cycle `ld_hit` gives the result of the tag compare and, on a hit, `ld_rdata` gives the stored word.
- R11: A store may issue in the `ld_block` cycle and proceeds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_issue | input | 1 | Store issues this cycle |
| st_addr | input | ADDR_W | Store word address |
| st_wdata | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Store byte enables |
| ld_issue | input | 1 | Load presented this cycle |
| ld_addr | input | ADDR_W | Load word address |
| fill_vld | input | 1 | Install a line |
| fill_addr | input | ADDR_W | Install address |
| fill_data | input | DATA_W | Install word |
| ld_block | output | 1 | Loads must not issue this cycle |
| dwr_en | output | 1 | Data-array store write this cycle |
| st_miss | output | 1 | Store in its third stage missed |
| st_miss_addr | output | ADDR_W | Address of the missing store |
| ld_rsp_vld | output | 1 | Load response valid |
| ld_hit | output | 1 | Load hit |
| ld_rdata | output | DATA_W | Load data on a hit |

## Verification
The assertions take for granted that a line install never coincides with a load or a store issue, and that it never arrives while a store is in its second or third stage. Under those conditions the single data port and the tag read order are always unambiguous. The stimulus installs lines only in quiet cycles, with both store stages empty. The stimulus does present loads in blocked cycles on purpose, because dropping them is defined behaviour and is checked.

// File: rtl/dcsp_pkg.sv
package dcsp_pkg;
   localparam int BYTE_W = 8;

   // User of the single data-array port in a given cycle
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FILL  = 2'd2,
      ACC_LOAD  = 2'd3
   } acc_kind_e;
endpackage

// File: rtl/dcsp_tag_array.sv
module dcsp_tag_array #(
   parameter int IDX_W = 4,
   parameter int TAG_W = 8,
   parameter int NRD   = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       fill_en,
   input  logic [IDX_W-1:0]           fill_idx,
   input  logic [TAG_W-1:0]           fill_tag,
   input  logic [NRD-1:0]             rd_en,
   input  logic [NRD-1:0][IDX_W-1:0]  rd_idx,
   output logic [NRD-1:0]             rd_vld,
   output logic [NRD-1:0][TAG_W-1:0]  rd_tag
);
   localparam int NL = 1 << IDX_W;

   logic [NL-1:0]    vld_q;
   logic [TAG_W-1:0] tag_q [NL];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       vld_q           <= '0;
      else if (fill_en) vld_q[fill_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (fill_en) tag_q[fill_idx] <= fill_tag;
   end

   // One registered read port per requester; reads see the pre-edge state
   for (genvar p = 0; p < NRD; p++) begin : g_rd
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        rd_vld[p] <= 1'b0;
         else if (rd_en[p]) rd_vld[p] <= vld_q[rd_idx[p]];
      end
      always_ff @(posedge clk) begin
         if (rd_en[p]) rd_tag[p] <= tag_q[rd_idx[p]];
      end
   end
endmodule

// File: rtl/dcsp_data_array.sv
module dcsp_data_array #(
   parameter int IDX_W = 4,
   parameter int NB    = 4
) (
   input  logic                          clk,
   input  logic                          wr_en,
   input  logic [NB-1:0]                 wr_be,
   input  logic                          rd_en,
   input  logic [IDX_W-1:0]              idx,
   input  logic [NB*dcsp_pkg::BYTE_W-1:0] wdata,
   output logic [NB*dcsp_pkg::BYTE_W-1:0] rdata
);
   localparam int NL = 1 << IDX_W;
   localparam int BW = dcsp_pkg::BYTE_W;

   // Single port, split into independently enabled byte lanes
   for (genvar b = 0; b < NB; b++) begin : g_lane
      logic [BW-1:0] mem [NL];
      logic [BW-1:0] rd_q;
      always_ff @(posedge clk) begin
         if (wr_en && wr_be[b]) mem[idx] <= wdata[b*BW +: BW];
         if (rd_en)             rd_q     <= mem[idx];
      end
      assign rdata[b*BW +: BW] = rd_q;
   end
endmodule

// File: rtl/dcsp_interlock.sv
module dcsp_interlock #(
   parameter int DIST = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic st_issue,
   output logic ld_block
);
   if (DIST < 1) begin : g_bad_dist
      $error("dcsp_interlock: DIST must be at least 1");
   end

   if (DIST == 1) begin : g_one
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= st_issue;
      end
      assign ld_block = q;
   end else begin : g_chain
      logic [DIST-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '0;
         else        sh_q <= {sh_q[DIST-2:0], st_issue};
      end
      assign ld_block = sh_q[DIST-1];
   end
endmodule

// File: rtl/dcache_store_pipe.sv
module dcache_store_pipe
   import dcsp_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 st_issue,
   input  logic [ADDR_W-1:0]    st_addr,
   input  logic [DATA_W-1:0]    st_wdata,
   input  logic [DATA_W/8-1:0]  st_be,
   input  logic                 ld_issue,
   input  logic [ADDR_W-1:0]    ld_addr,
   input  logic                 fill_vld,
   input  logic [ADDR_W-1:0]    fill_addr,
   input  logic [DATA_W-1:0]    fill_data,
   output logic                 ld_block,
   output logic                 dwr_en,
   output logic                 st_miss,
   output logic [ADDR_W-1:0]    st_miss_addr,
   output logic                 ld_rsp_vld,
   output logic                 ld_hit,
   output logic [DATA_W-1:0]    ld_rdata
);
   localparam int NB       = DATA_W / BYTE_W;
   localparam int TAG_W    = ADDR_W - IDX_W;
   localparam int WR_STAGE = 2;   // cycles from issue to data write
   localparam int P_ST     = 0;   // tag read port of the store stream
   localparam int P_LD     = 1;   // tag read port of the load stream

   if (DATA_W % BYTE_W != 0) begin : g_bad_data
      $error("dcache_store_pipe: DATA_W must be a whole number of bytes");
   end
   if (IDX_W < 1 || IDX_W >= ADDR_W) begin : g_bad_idx
      $error("dcache_store_pipe: IDX_W must lie in 1..ADDR_W-1");
   end

   // ---------------- stage 1: tag reads ----------------
   logic                       ld_acc;
   logic [1:0]                 trd_en;
   logic [1:0][IDX_W-1:0]      trd_idx;
   logic [1:0]                 trd_vld;
   logic [1:0][TAG_W-1:0]      trd_tag;

   assign ld_acc           = ld_issue & ~ld_block;
   assign trd_en[P_ST]     = st_issue;
   assign trd_en[P_LD]     = ld_acc;
   assign trd_idx[P_ST]    = st_addr[IDX_W-1:0];
   assign trd_idx[P_LD]    = ld_addr[IDX_W-1:0];

   dcsp_tag_array #(
      .IDX_W (IDX_W),
      .TAG_W (TAG_W),
      .NRD   (2)
   ) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .fill_en  (fill_vld),
      .fill_idx (fill_addr[IDX_W-1:0]),
      .fill_tag (fill_addr[ADDR_W-1:IDX_W]),
      .rd_en    (trd_en),
      .rd_idx   (trd_idx),
      .rd_vld   (trd_vld),
      .rd_tag   (trd_tag)
   );

   // ---------------- stage 2: hit compare ----------------
   logic              s2_vld;
   logic [ADDR_W-1:0] s2_addr;
   logic [DATA_W-1:0] s2_data;
   logic [NB-1:0]     s2_be;
   logic              s2_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s2_vld <= 1'b0;
      else        s2_vld <= st_issue;
   end
   always_ff @(posedge clk) begin
      if (st_issue) begin
         s2_addr <= st_addr;
         s2_data <= st_wdata;
         s2_be   <= st_be;
      end
   end

   assign s2_hit = s2_vld & trd_vld[P_ST] &
                   (trd_tag[P_ST] == s2_addr[ADDR_W-1:IDX_W]);

   // ---------------- stage 3: data write ----------------
   logic              s3_vld;
   logic              s3_hit;
   logic [ADDR_W-1:0] s3_addr;
   logic [DATA_W-1:0] s3_data;
   logic [NB-1:0]     s3_be;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s3_vld <= 1'b0;
         s3_hit <= 1'b0;
      end else begin
         s3_vld <= s2_vld;
         s3_hit <= s2_hit;
      end
   end
   always_ff @(posedge clk) begin
      if (s2_vld) begin
         s3_addr <= s2_addr;
         s3_data <= s2_data;
         s3_be   <= s2_be;
      end
   end

   assign dwr_en       = s3_vld & s3_hit;
   assign st_miss      = s3_vld & ~s3_hit;
   assign st_miss_addr = s3_addr;

   // ---------------- data-array port arbitration ----------------
   acc_kind_e         kind;
   logic              d_we;
   logic              d_re;
   logic [NB-1:0]     d_be;
   logic [IDX_W-1:0]  d_idx;
   logic [DATA_W-1:0] d_wdata;
   logic [DATA_W-1:0] d_rdata;

   always_comb begin
      if (dwr_en)        kind = ACC_STORE;
      else if (fill_vld) kind = ACC_FILL;
      else if (ld_acc)   kind = ACC_LOAD;
      else               kind = ACC_NONE;
   end

   always_comb begin
      d_we    = 1'b0;
      d_re    = 1'b0;
      d_be    = '0;
      d_idx   = ld_addr[IDX_W-1:0];
      d_wdata = s3_data;
      unique case (kind)
         ACC_STORE: begin
            d_we  = 1'b1;
            d_be  = s3_be;
            d_idx = s3_addr[IDX_W-1:0];
         end
         ACC_FILL: begin
            d_we    = 1'b1;
            d_be    = '1;
            d_idx   = fill_addr[IDX_W-1:0];
            d_wdata = fill_data;
         end
         ACC_LOAD: d_re = 1'b1;
         default:  d_re = 1'b0;
      endcase
   end

   dcsp_data_array #(
      .IDX_W (IDX_W),
      .NB    (NB)
   ) u_data (
      .clk   (clk),
      .wr_en (d_we),
      .wr_be (d_be),
      .rd_en (d_re),
      .idx   (d_idx),
      .wdata (d_wdata),
      .rdata (d_rdata)
   );

   // ---------------- load response ----------------
   logic             lr_vld;
   logic [TAG_W-1:0] lr_tag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lr_vld <= 1'b0;
      else        lr_vld <= ld_acc;
   end
   always_ff @(posedge clk) begin
      if (ld_acc) lr_tag <= ld_addr[ADDR_W-1:IDX_W];
   end

   assign ld_rsp_vld = lr_vld;
   assign ld_hit     = lr_vld & trd_vld[P_LD] & (trd_tag[P_LD] == lr_tag);
   assign ld_rdata   = d_rdata;

   // ---------------- issue interlock ----------------
   dcsp_interlock #(
      .DIST (WR_STAGE)
   ) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .st_issue (st_issue),
      .ld_block (ld_block)
   );
endmodule

// File: rtl/dcsp_checker.sv
module dcsp_checker (
   input logic clk,
   input logic rst_n,
   input logic st_issue,
   input logic ld_issue,
   input logic ld_block,
   input logic dwr_en,
   input logic st_miss,
   input logic ld_rsp_vld
);
   // R6: the bubble lands two cycles after every store
   a_r6_block_after_store: assert property (@(posedge clk) disable iff (!rst_n)
      st_issue |-> ##2 ld_block);

   // R6: no bubble without a store two cycles earlier
   a_r6_block_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ld_block) |-> $past(st_issue, 2));

   // R3: a data write happens only in a bubble cycle
   a_r3_write_in_bubble: assert property (@(posedge clk) disable iff (!rst_n)
      dwr_en |-> ld_block);

   // R5: one store cannot both write and miss
   a_r5_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(dwr_en && st_miss));

   // R7: a blocked load gets no response
   a_r7_blocked_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_issue && ld_block) |=> !ld_rsp_vld);

   // R10: every response follows an accepted load
   a_r10_rsp_cause: assert property (@(posedge clk) disable iff (!rst_n)
      ld_rsp_vld |-> $past(ld_issue && !ld_block));
endmodule

bind dcache_store_pipe dcsp_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .st_issue   (st_issue),
   .ld_issue   (ld_issue),
   .ld_block   (ld_block),
   .dwr_en     (dwr_en),
   .st_miss    (st_miss),
   .ld_rsp_vld (ld_rsp_vld)
);

// File: tb/dcache_store_pipe_tb.sv
module dcache_store_pipe_tb;
   localparam int AW = 12;
   localparam int DW = 32;
   localparam int IW = 4;
   localparam int NB = DW / 8;
   localparam int NL = 1 << IW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          st_issue, ld_issue, fill_vld;
   logic [AW-1:0] st_addr, ld_addr, fill_addr;
   logic [DW-1:0] st_wdata, fill_data;
   logic [NB-1:0] st_be;
   logic          ld_block, dwr_en, st_miss, ld_rsp_vld, ld_hit;
   logic [AW-1:0] st_miss_addr;
   logic [DW-1:0] ld_rdata;

   always #10 clk = ~clk;   // 50 MHz

   dcache_store_pipe #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .st_issue(st_issue), .st_addr(st_addr), .st_wdata(st_wdata), .st_be(st_be),
      .ld_issue(ld_issue), .ld_addr(ld_addr),
      .fill_vld(fill_vld), .fill_addr(fill_addr), .fill_data(fill_data),
      .ld_block(ld_block), .dwr_en(dwr_en), .st_miss(st_miss),
      .st_miss_addr(st_miss_addr), .ld_rsp_vld(ld_rsp_vld),
      .ld_hit(ld_hit), .ld_rdata(ld_rdata)
   );

   int    n_chk  = 0;
   int    n_fail = 0;
   string phase  = "R1";

   // Behavioural model: cache contents plus a queue of stores in flight
   typedef struct {
      int          age;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
      logic [NB-1:0] be;
      bit          hit;
   } st_rec_t;

   st_rec_t       inflight[$];
   bit            m_val [NL];
   int            m_tag [NL];
   logic [DW-1:0] m_dat [NL];
   bit            r_v, r_hit;
   logic [DW-1:0] r_dat;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit tag_hit(input logic [AW-1:0] a);
      return m_val[a[IW-1:0]] && (m_tag[a[IW-1:0]] == int'(a[AW-1:IW]));
   endfunction

   function automatic bit blocked_now();
      foreach (inflight[i]) if (inflight[i].age == 2) return 1'b1;
      return 1'b0;
   endfunction

   // One clock: model the edge, then compare at the following negedge
   task automatic cycle();
      bit blk;
      @(posedge clk);
      blk = blocked_now();
      r_v = ld_issue && !blk;
      if (r_v) begin
         r_hit = tag_hit(ld_addr);
         r_dat = m_dat[ld_addr[IW-1:0]];
      end
      foreach (inflight[i]) begin
         if (inflight[i].age == 2 && inflight[i].hit) begin
            for (int b = 0; b < NB; b++)
               if (inflight[i].be[b])
                  m_dat[inflight[i].addr[IW-1:0]][b*8 +: 8] = inflight[i].data[b*8 +: 8];
         end
      end
      while (inflight.size() > 0 && inflight[0].age >= 2) void'(inflight.pop_front());
      foreach (inflight[i]) inflight[i].age++;
      if (st_issue) begin
         st_rec_t s;
         s.age = 1; s.addr = st_addr; s.data = st_wdata; s.be = st_be;
         s.hit = tag_hit(st_addr);
         inflight.push_back(s);
      end
      if (fill_vld) begin
         m_val[fill_addr[IW-1:0]] = 1'b1;
         m_tag[fill_addr[IW-1:0]] = int'(fill_addr[AW-1:IW]);
         m_dat[fill_addr[IW-1:0]] = fill_data;
      end
      @(negedge clk);
      begin
         bit e_blk, e_wr, e_miss;
         logic [AW-1:0] e_ma;
         e_blk = 0; e_wr = 0; e_miss = 0; e_ma = '0;
         foreach (inflight[i]) if (inflight[i].age == 2) begin
            e_blk = 1; e_wr = inflight[i].hit; e_miss = !inflight[i].hit;
            e_ma = inflight[i].addr;
         end
         chk(ld_block == e_blk, phase, "R6 ld_block", 64'(ld_block), 64'(e_blk));
         chk(dwr_en == e_wr, phase, "R3 dwr_en", 64'(dwr_en), 64'(e_wr));
         chk(st_miss == e_miss, phase, "R5 st_miss", 64'(st_miss), 64'(e_miss));
         if (e_miss)
            chk(st_miss_addr == e_ma, phase, "R5 st_miss_addr", 64'(st_miss_addr), 64'(e_ma));
         chk(ld_rsp_vld == r_v, phase, "R10 ld_rsp_vld", 64'(ld_rsp_vld), 64'(r_v));
         if (r_v) chk(ld_hit == r_hit, phase, "R10 ld_hit", 64'(ld_hit), 64'(r_hit));
         if (r_v && r_hit)
            chk(ld_rdata == r_dat, phase, "R4 ld_rdata", 64'(ld_rdata), 64'(r_dat));
      end
      st_issue = 0; ld_issue = 0; fill_vld = 0;
   endtask

   task automatic do_fill(input logic [AW-1:0] a, input logic [DW-1:0] d);
      fill_vld = 1; fill_addr = a; fill_data = d; cycle();
   endtask
   task automatic set_st(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NB-1:0] be);
      st_issue = 1; st_addr = a; st_wdata = d; st_be = be;
   endtask
   task automatic set_ld(input logic [AW-1:0] a);
      ld_issue = 1; ld_addr = a;
   endtask
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cycle();
   endtask
   // Load and return the word seen in the response cycle
   task automatic read_word(input logic [AW-1:0] a, output logic [DW-1:0] d, output bit h);
      set_ld(a); cycle(); d = ld_rdata; h = ld_hit;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : stim
      logic [DW-1:0] w;
      bit h;
      st_issue = 0; ld_issue = 0; fill_vld = 0;
      st_addr = '0; ld_addr = '0; fill_addr = '0;
      st_wdata = '0; fill_data = '0; st_be = '0;
      foreach (m_val[i]) begin m_val[i] = 0; m_tag[i] = 0; m_dat[i] = '0; end
      r_v = 0; r_hit = 0; r_dat = '0;
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1: quiet outputs and empty cache after reset
      phase = "R1";
      chk(!ld_block && !dwr_en && !st_miss && !ld_rsp_vld, "R1", "outputs",
          64'({ld_block, dwr_en, st_miss, ld_rsp_vld}), 64'(0));
      read_word(12'h035, w, h);
      chk(h == 0, "R1", "ld_hit after reset", 64'(h), 64'(0));

      // R2: install lines, then hit on them
      phase = "R2";
      do_fill(12'h035, 32'h11223344);
      do_fill(12'h046, 32'h55667788);
      read_word(12'h035, w, h);
      chk(h && w == 32'h11223344, "R2", "installed word", 64'(w), 64'h11223344);

      // R10: same index, other tag misses
      phase = "R10";
      read_word(12'h075, w, h);
      chk(h == 0, "R10", "tag mismatch", 64'(h), 64'(0));

      // R3/R4: partial store hit, byte 1 only
      phase = "R4";
      set_st(12'h035, 32'hAABBCCDD, 4'b0010); cycle();
      idle(3);
      read_word(12'h035, w, h);
      chk(w == 32'h1122CC44, "R4", "byte merge", 64'(w), 64'h1122CC44);

      // R5: store miss leaves word alone
      phase = "R5";
      set_st(12'h0F5, 32'hDEADBEEF, 4'hF); cycle();
      idle(3);
      read_word(12'h035, w, h);
      chk(w == 32'h1122CC44, "R5", "miss no write", 64'(w), 64'h1122CC44);

      // R9: load one cycle after store sees old, three after sees new
      phase = "R9";
      set_st(12'h046, 32'h0A0B0C0D, 4'hF); cycle();
      read_word(12'h046, w, h);
      chk(w == 32'h55667788, "R9", "old word", 64'(w), 64'h55667788);
      cycle();
      read_word(12'h046, w, h);
      chk(w == 32'h0A0B0C0D, "R9", "new word", 64'(w), 64'h0A0B0C0D);

      // R7: load in the bubble is dropped
      phase = "R7";
      set_st(12'h046, 32'h0, 4'h0); cycle();
      cycle();
      set_ld(12'h046); cycle();
      chk(ld_rsp_vld == 0, "R7", "dropped load", 64'(ld_rsp_vld), 64'(0));
      idle(2);

      // R8/R11: back-to-back stores, one in each bubble
      phase = "R8";
      set_st(12'h035, 32'h000000A1, 4'b0001); cycle();
      set_st(12'h035, 32'h000000B2, 4'b0001); cycle();
      set_st(12'h035, 32'h0000C300, 4'b0010); cycle();
      phase = "R11";
      set_st(12'h035, 32'h000000D4, 4'b0001); cycle();
      idle(3);
      read_word(12'h035, w, h);
      chk(w == 32'h1122C3D4, "R8", "last writer wins", 64'(w), 64'h1122C3D4);

      // Mixed traffic; installs only when the store stages are empty
      phase = "R3";
      for (int i = 0; i < 600; i++) begin
         logic [AW-1:0] a;
         a = {6'($urandom_range(0, 1)), 2'b0, 4'($urandom_range(0, 3))};
         if (inflight.size() == 0 && $urandom_range(0, 9) == 0) begin
            do_fill(a, $urandom);
         end else begin
            if ($urandom_range(0, 1) == 1) set_st(a, $urandom, 4'($urandom));
            if ($urandom_range(0, 4) < 2)
               set_ld({6'($urandom_range(0, 1)), 2'b0, 4'($urandom_range(0, 3))});
            cycle();
         end
      end
      idle(3);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule